// File: doc/BRIEF.md
# Fixed-Point Phase Correction Loop

This block corrects the phase of a complex baseband stream inside a receiver. Each accepted sample, with signed 16-bit real and imaginary parts in Q1.15, is multiplied by minus j times the current phase value. The result is the block's output. The same result also feeds a closed loop. A second-order recursive filter smooths the mixed signal. A quadratic offset detector takes the real part of the product of two filter taps. A proportional-integral stage turns the offset history into a phase correction, and that correction is added into the phase value the mixer uses for the next sample.

All arithmetic runs on one shared rounding multiplier and one saturating adder. A step sequencer spends 17 fast clock cycles on every sample. The input handshake is valid/ready, and ready stays low while a sample is being processed. Filter coefficients, loop gains and the phase value loaded at reset are quasi-static inputs. One output strobe marks each finished sample.

Top module: `phase_loop`

## Requirements
- R1: While rst_n is low at a rising edge, that edge clears the mixer history, the filter history, the offset history and the phase correction to zero and loads the phase register from phase_start. After reset, in_ready is 1, out_valid is 0, and out_re and out_im are 0.
- R2: A sample is taken at a rising edge where in_valid and in_ready are both 1. From the next cycle on, in_ready is 0. Anything presented on the input while in_ready is 0 is ignored. out_valid and in_ready both go high after the 18th rising edge counted from the accepting edge.
- R3: out_valid is high for exactly one cycle per accepted sample.
- R4: With P the phase value before this sample's update, out_re = mul(in_im, P) and out_im = sat(0 - mul(in_re, P)). The outputs stay unchanged until the next sample is processed.
- R5: mul(a,b) = floor((a*b + 2^14) / 2^15), clamped to [-32768, 32767]. Every sum is clamped to the same range after each single term is added or subtracted.
- R6: Per sample, the mixer history shifts (tap2 takes tap1, tap1 takes tap0) before the new mixer output enters tap0. The filter history shifts the same way. The new filter tap0 is then built, for real and imaginary parts separately, in this order: start at 0, subtract mul(f1,a1), subtract mul(f2,a2), add mul(m0,b0), add mul(m1,b1), add mul(m2,b2).
- R7: The offset is computed from the shifted taps as mul(f2re,f0re) minus mul(f2im,f0im). Offset history entry 0 takes the old entry 1, and entry 1 takes the new offset.
- R8: The phase correction is updated in this order: previous correction, add mul(Kp,o0), add mul(Ki,o1), subtract mul(Kp,o1). The phase register then becomes sat(phase + new correction). Both change only at the last step of a sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast processing clock |
| rst_n | input | 1 | active-low synchronous reset |
| in_valid | input | 1 | input sample offered |
| in_ready | output | 1 | block can take a sample |
| in_re | input | 16 | sample real part, Q1.15 |
| in_im | input | 16 | sample imaginary part, Q1.15 |
| coef_a1 | input | 16 | feedback coefficient for filter tap 1 |
| coef_a2 | input | 16 | feedback coefficient for filter tap 2 |
| coef_b0 | input | 16 | feed-forward coefficient for mixer tap 0 |
| coef_b1 | input | 16 | feed-forward coefficient for mixer tap 1 |
| coef_b2 | input | 16 | feed-forward coefficient for mixer tap 2 |
| gain_p | input | 16 | proportional loop gain |
| gain_i | input | 16 | integral loop gain |
| phase_start | input | 16 | phase value loaded at reset |
| out_valid | output | 1 | one-cycle strobe per finished sample |
| out_re | output | 16 | mixer output real part |
| out_im | output | 16 | mixer output imaginary part |

## Verification
The hardest condition to reach is clamping deep inside the live loop. Examples are the -1 × -1 product in the mixer, a saturating filter recursion and a correction that runs into its limit. It only appears after the loop has built up state over several samples. To get there, the stimulus uses full-scale coefficient and gain sets, phase seeds at both extremes, and opening samples at plus and minus full scale, followed by a pseudo-random stream. A bench model computes every output with its own clamped arithmetic and compares each sample. The stimulus also keeps in_valid high with changing data while the block is busy, to show that those values are ignored.

// File: rtl/phase_loop_pkg.sv
package phase_loop_pkg;
  localparam int DW        = 16;
  localparam int N_CH      = 2;
  localparam int N_TAP     = 3;
  localparam int FILT_BASE = 2;
  localparam int FILT_LEN  = 5;
  localparam int OFF_STEP  = FILT_BASE + N_CH * FILT_LEN;
  localparam int PI_STEP   = OFF_STEP + 2;
  localparam int N_STEPS   = PI_STEP + 3;
  localparam int SW        = $clog2(N_STEPS);
  localparam int CW        = $clog2(N_CH);
  localparam int XW        = 2 * DW + 1;

  typedef logic signed [DW-1:0] q_t;
  typedef logic signed [XW-1:0] x_t;

  localparam x_t HI  = {{(DW+2){1'b0}}, {(DW-1){1'b1}}};
  localparam x_t LO  = {{(DW+2){1'b1}}, {(DW-1){1'b0}}};
  localparam x_t RND = {{(DW+2){1'b0}}, 1'b1, {(DW-2){1'b0}}};

  function automatic q_t q_clip(input x_t v);
    if (v > HI) return HI[DW-1:0];
    if (v < LO) return LO[DW-1:0];
    return v[DW-1:0];
  endfunction

  function automatic x_t q_ext(input q_t a);
    return {{(DW+1){a[DW-1]}}, a};
  endfunction

  // rounded Q1.15 product, clamped
  function automatic q_t q_mul(input q_t a, input q_t b);
    x_t p;
    p = q_ext(a) * q_ext(b) + RND;
    return q_clip(p >>> (DW-1));
  endfunction

  // base plus or minus one term, clamped
  function automatic q_t q_add(input q_t base, input q_t v, input logic sub);
    x_t s;
    s = sub ? (q_ext(base) - q_ext(v)) : (q_ext(base) + q_ext(v));
    return q_clip(s);
  endfunction
endpackage

// File: rtl/pl_seq.sv
module pl_seq
  import phase_loop_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          accept,
  output logic          busy,
  output logic [SW-1:0] step,
  output logic          last,
  output logic          out_valid
);
  localparam logic [SW-1:0] LAST_STEP = SW'(N_STEPS - 1);

  assign in_ready = !busy;
  assign accept   = in_valid && !busy;
  assign last     = busy && (step == LAST_STEP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      step      <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= last;
      if (accept) begin
        busy <= 1'b1;
        step <= '0;
      end else if (busy) begin
        if (last) busy <= 1'b0;
        else      step <= step + 1'b1;
      end
    end
  end

  // R2: a taken sample closes the input on the next cycle
  a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);
  // R2: the strobe comes together with the reopened input
  a_r2_ready_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);
  // R3: single-cycle strobe
  a_r3_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R3: a strobe only ends a running sequence
  a_r3_valid_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(busy));
endmodule

// File: rtl/pl_mac.sv
module pl_mac
  import phase_loop_pkg::*;
(
  input  q_t   op_a,
  input  q_t   op_b,
  input  q_t   base,
  input  logic sub,
  output q_t   res
);
  q_t prod;
  assign prod = q_mul(op_a, op_b);
  assign res  = q_add(base, prod, sub);
endmodule

// File: rtl/phase_loop.sv
module phase_loop
  import phase_loop_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [15:0]   in_re,
  input  logic signed [15:0]   in_im,
  input  logic signed [15:0]   coef_a1,
  input  logic signed [15:0]   coef_a2,
  input  logic signed [15:0]   coef_b0,
  input  logic signed [15:0]   coef_b1,
  input  logic signed [15:0]   coef_b2,
  input  logic signed [15:0]   gain_p,
  input  logic signed [15:0]   gain_i,
  input  logic signed [15:0]   phase_start,
  output logic                 out_valid,
  output logic signed [15:0]   out_re,
  output logic signed [15:0]   out_im
);
  localparam logic [CW-1:0] CH_IM = CW'(1);

  logic          accept, busy, seq_last;
  logic [SW-1:0] step;

  q_t xr_q, xi_q, phase_q, pc_q, acc_q;
  q_t m_q [N_CH][N_TAP];
  q_t d_q [N_CH][N_TAP];
  q_t o_q [2];

  q_t   op_a, op_b, base, res;
  logic sub, first, use_pc;

  pl_seq u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .accept(accept), .busy(busy), .step(step), .last(seq_last),
    .out_valid(out_valid)
  );

  // step schedule: operands for the shared multiplier
  always_comb begin
    int s, k;
    logic [CW-1:0] ch;
    op_a = '0; op_b = '0; sub = 1'b0; first = 1'b0; use_pc = 1'b0;
    s  = int'(step);
    k  = 0;
    ch = '0;
    if (s < FILT_BASE) begin
      first = 1'b1;
      op_b  = phase_q;
      op_a  = (s == 0) ? xi_q : xr_q;
      sub   = (s == 1);
    end else if (s < OFF_STEP) begin
      ch = (s >= FILT_BASE + FILT_LEN) ? CH_IM : '0;
      k  = (s - FILT_BASE) % FILT_LEN;
      case (k)
        0: begin op_a = d_q[ch][1]; op_b = coef_a1; first = 1'b1; sub = 1'b1; end
        1: begin op_a = d_q[ch][2]; op_b = coef_a2; sub = 1'b1; end
        2: begin op_a = m_q[ch][0]; op_b = coef_b0; end
        3: begin op_a = m_q[ch][1]; op_b = coef_b1; end
        default: begin op_a = m_q[ch][2]; op_b = coef_b2; end
      endcase
    end else if (s < PI_STEP) begin
      ch    = (s == OFF_STEP) ? '0 : CH_IM;
      op_a  = d_q[ch][2];
      op_b  = d_q[ch][0];
      first = (s == OFF_STEP);
      sub   = (s != OFF_STEP);
    end else begin
      first  = (s == PI_STEP);
      use_pc = first;
      case (s - PI_STEP)
        0: begin op_a = gain_p; op_b = o_q[0]; end
        1: begin op_a = gain_i; op_b = o_q[1]; end
        default: begin op_a = gain_p; op_b = o_q[1]; sub = 1'b1; end
      endcase
    end
  end

  assign base = first ? (use_pc ? pc_q : '0) : acc_q;

  pl_mac u_mac (.op_a(op_a), .op_b(op_b), .base(base), .sub(sub), .res(res));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < N_CH; c++) begin
        for (int t = 0; t < N_TAP; t++) begin
          m_q[CW'(c)][t] <= '0;
          d_q[CW'(c)][t] <= '0;
        end
      end
      o_q[0]  <= '0;
      o_q[1]  <= '0;
      pc_q    <= '0;
      acc_q   <= '0;
      xr_q    <= '0;
      xi_q    <= '0;
      phase_q <= phase_start;
    end else if (accept) begin
      xr_q <= in_re;
      xi_q <= in_im;
      for (int c = 0; c < N_CH; c++) begin
        m_q[CW'(c)][2] <= m_q[CW'(c)][1];
        m_q[CW'(c)][1] <= m_q[CW'(c)][0];
        d_q[CW'(c)][2] <= d_q[CW'(c)][1];
        d_q[CW'(c)][1] <= d_q[CW'(c)][0];
      end
      o_q[0] <= o_q[1];
    end else if (busy) begin
      acc_q <= res;
      case (int'(step))
        0:                          m_q[0][0]     <= res;
        1:                          m_q[CH_IM][0] <= res;
        FILT_BASE + FILT_LEN - 1:   d_q[0][0]     <= res;
        OFF_STEP - 1:               d_q[CH_IM][0] <= res;
        OFF_STEP + 1:               o_q[1]        <= res;
        N_STEPS - 1: begin
          pc_q    <= res;
          phase_q <= q_add(phase_q, res, 1'b0);
        end
        default: ;
      endcase
    end
  end

  assign out_re = m_q[0][0];
  assign out_im = m_q[CH_IM][0];

  // R1: reset leaves a cleared loop and the seeded phase
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (pc_q == '0 && o_q[1] == '0 && out_re == '0 && out_im == '0
                && phase_q == phase_start));
  // R8: phase moves only at the closing step of a sample
  a_r8_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_last |=> $stable(phase_q));
  // R8: correction moves only at the closing step as well
  a_r8_corr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_last |=> $stable(pc_q));
  // R4: outputs hold while idle and nothing is taken
  a_r4_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !accept) |=> ($stable(out_re) && $stable(out_im)));
endmodule

// File: tb/phase_loop_test.sv
module phase_loop_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready, out_valid;
  logic signed [15:0] in_re = '0, in_im = '0;
  logic signed [15:0] a1 = '0, a2 = '0, b0 = '0, b1 = '0, b2 = '0;
  logic signed [15:0] kp = '0, ki = '0, ps = '0;
  logic signed [15:0] out_re, out_im;

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  // bench model state
  int mm [2][3];
  int dd [2][3];
  int oo [2];
  int pcm, phm;
  int ca1, ca2, cb0, cb1, cb2, ckp, cki, cps;

  always #4 clk = ~clk;

  phase_loop uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_re(in_re), .in_im(in_im), .coef_a1(a1), .coef_a2(a2),
    .coef_b0(b0), .coef_b1(b1), .coef_b2(b2), .gain_p(kp), .gain_i(ki),
    .phase_start(ps), .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
  );

  function automatic int lim(input longint v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  // rounding product via floor division
  function automatic int rmul(input int a, input int b);
    longint r, q;
    r = longint'(a) * longint'(b) + 16384;
    q = r / 32768;
    if (r < 0 && (r % 32768) != 0) q = q - 1;
    return lim(q);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 2; c++)
      for (int t = 0; t < 3; t++) begin mm[c][t] = 0; dd[c][t] = 0; end
    oo[0] = 0; oo[1] = 0; pcm = 0; phm = cps;
  endtask

  task automatic model_step(input int xr, input int xi);
    int t, off;
    for (int c = 0; c < 2; c++) begin
      mm[c][2] = mm[c][1]; mm[c][1] = mm[c][0];
      dd[c][2] = dd[c][1]; dd[c][1] = dd[c][0];
    end
    oo[0] = oo[1];
    mm[0][0] = rmul(xi, phm);
    mm[1][0] = lim(-longint'(rmul(xr, phm)));
    for (int c = 0; c < 2; c++) begin
      t = lim(-longint'(rmul(dd[c][1], ca1)));
      t = lim(longint'(t) - rmul(dd[c][2], ca2));
      t = lim(longint'(t) + rmul(mm[c][0], cb0));
      t = lim(longint'(t) + rmul(mm[c][1], cb1));
      t = lim(longint'(t) + rmul(mm[c][2], cb2));
      dd[c][0] = t;
    end
    off = rmul(dd[0][2], dd[0][0]);
    off = lim(longint'(off) - rmul(dd[1][2], dd[1][0]));
    oo[1] = off;
    pcm = lim(longint'(pcm) + rmul(ckp, oo[0]));
    pcm = lim(longint'(pcm) + rmul(cki, oo[1]));
    pcm = lim(longint'(pcm) - rmul(ckp, oo[1]));
    phm = lim(longint'(phm) + pcm);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
    check("R1 in_ready after reset", int'(in_ready), 1);
    check("R1 out_valid after reset", int'(out_valid), 0);
    check("R1 out_re after reset", int'(out_re), 0);
    check("R1 out_im after reset", int'(out_im), 0);
  endtask

  task automatic send(input int xr, input int xi);
    int cnt;
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_re = 16'(xr);
    in_im = 16'(xi);
    model_step(xr, xi);
    @(negedge clk);
    check("R2 in_ready low after accept", int'(in_ready), 0);
    // R2: junk held on the input while busy must be ignored
    in_re = 16'(xr ^ 32'h5a5a);
    in_im = 16'(xi ^ 32'h3c3c);
    cnt = 1;
    while (!out_valid && cnt < 40) begin
      @(negedge clk);
      cnt++;
      if (!out_valid && in_ready) check("R2 in_ready low while busy", 1, 0);
    end
    check("R2 latency to out_valid", cnt, 18);
    check("R2 in_ready back with out_valid", int'(in_ready), 1);
    check("R4 R5 R6 R7 R8 out_re", int'(out_re), mm[0][0]);
    check("R4 R5 R6 R7 R8 out_im", int'(out_im), mm[1][0]);
    in_valid = 1'b0;
    @(negedge clk);
    check("R3 out_valid single cycle", int'(out_valid), 0);
    check("R4 out_re held", int'(out_re), mm[0][0]);
  endtask

  task automatic set_cfg(input int k);
    case (k)
      0: begin ca1 = -16384; ca2 = 8192;  cb0 = 8192;   cb1 = 16384;  cb2 = 8192;   ckp = 2000;   cki = 300;    cps = 12000;  end
      1: begin ca1 = -32768; ca2 = 32767; cb0 = 32767;  cb1 = 32767;  cb2 = 32767;  ckp = 32767;  cki = 32767;  cps = -32768; end
      2: begin ca1 = 0;      ca2 = 0;     cb0 = 32767;  cb1 = 0;      cb2 = 0;      ckp = 0;      cki = 0;      cps = 20000;  end
      3: begin ca1 = 10000;  ca2 = -3000; cb0 = -12000; cb1 = 7000;   cb2 = -500;   ckp = -5000;  cki = 4000;   cps = -9000;  end
      4: begin ca1 = 20000;  ca2 = -20000;cb0 = -32768; cb1 = -32768; cb2 = -32768; ckp = -32768; cki = -32768; cps = 32767;  end
      default: begin ca1 = -3000; ca2 = 1500; cb0 = 4000; cb1 = -2500; cb2 = 900; ckp = 12000; cki = -7000; cps = 700; end
    endcase
    a1 = 16'(ca1); a2 = 16'(ca2); b0 = 16'(cb0); b1 = 16'(cb1); b2 = 16'(cb2);
    kp = 16'(ckp); ki = 16'(cki); ps = 16'(cps);
  endtask

  initial begin
    for (int k = 0; k < 6; k++) begin
      set_cfg(k);
      do_reset();
      for (int n = 0; n < 30; n++) begin
        int xr, xi;
        seed = seed * 32'd1664525 + 32'd1013904223;
        xr = int'($signed(seed[31:16]));
        xi = int'($signed(seed[23:8]));
        if (n == 0) begin xr = -32768; xi = -32768; end
        if (n == 1) begin xr = 32767;  xi = 32767;  end
        if (n == 2) begin xr = 32767;  xi = -32768; end
        send(xr, xi);
      end
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule